// File: doc/BRIEF.md
# Allocation Range Tracking Cache

This block keeps a small table of heap regions that software has just allocated but has not yet written. A cache controller presents each store, or each store that missed, to the block. The block reports whether the address falls inside a tracked region. It also reports whether the store is an initializing write, meaning the first write to a line whose old contents are meaningless. On an initializing write the controller can install the line directly and skip the fetch from memory.

Allocation events create a table entry from a byte address and a byte size. The region is widened outward to whole 64-byte blocks. Free events remove entries by the region's first block. Each entry is kept as a pair of block numbers, a low end and an exclusive high end. A single entry therefore covers a region of any size.

An initializing write shrinks its entry, and the sweep mode sets how. Forward mode consumes blocks from the low end. Bidirectional mode consumes from either end. Interleaved mode follows fixed-stride passes over the region. An entry with nothing left to track frees itself. When the table is full, a new allocation replaces the oldest entry.

Top module: `alloc_range_tracker`

## Requirements
- R1: After reset the table holds no entries, and every store misses: `hit_o`, `init_o` and `hit_idx_o` are all 0.
- R2: An allocation with nonzero size covers the blocks from floor(addr/64) up to ceil((addr+size)/64)-1. A store whose block lies inside that span hits, and a store outside it misses. An allocation of size zero creates no entry.
- R3: The lookup result appears in the same cycle as the store. `hit_idx_o` gives the matching entry, and when several entries match, the lowest index is reported. With no store or no match, `hit_idx_o` is 0 and `init_o` is 0.
- R4: An allocation takes effect at the end of its cycle, so a store in the same cycle does not see the new region.
- R5: When `mode_i` is 0 or 3 (forward sweep), a store to the entry's low block is initializing and raises the low end by one block. Any other hit is non-initializing and leaves the entry unchanged.
- R6: When `mode_i` is 1 (bidirectional sweep), a store to the low block raises the low end by one block. A store to the highest block lowers the high end by one block. Both cases are initializing writes, and the low-block case wins when the two coincide.
- R7: When `mode_i` is 2 (interleaved sweep), a store to the entry's cursor block is initializing. The cursor then steps by STRIDE_BLKS blocks while it stays inside the region. Otherwise the low end rises by one block and the cursor restarts at the new low block. The cursor starts at the low block on allocation. An initializing write in forward or bidirectional mode also moves the cursor to the new low block.
- R8: An entry is removed when its low end reaches its high end. In interleaved mode it is also removed when the low end reaches the allocation's first block plus STRIDE_BLKS. Afterwards, stores to its former blocks miss.
- R9: A free event removes every entry whose original first block (allocation address divided by 64) equals the freed address divided by 64, even after truncation. A free that matches no entry changes nothing.
- R10: A new entry takes the lowest-numbered empty slot. If no slot is empty, it replaces the entry allocated longest ago.
- R11: Within one cycle, truncation and free removals are applied before the allocation. An allocation can therefore reuse a slot released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Sweep mode: 0/3 forward, 1 bidirectional, 2 interleaved |
| alloc_vld_i | input | 1 | Allocation event |
| alloc_addr_i | input | 32 | Allocation byte address |
| alloc_size_i | input | 32 | Allocation size in bytes |
| free_vld_i | input | 1 | Free event |
| free_addr_i | input | 32 | Address of the region being freed |
| st_vld_i | input | 1 | Store lookup request |
| st_addr_i | input | 32 | Store byte address |
| hit_o | output | 1 | Store falls inside a tracked region |
| init_o | output | 1 | Store is an initializing write |
| hit_idx_o | output | $clog2(DEPTH) | Slot of the matching entry |

## Verification
A corrupted low end, high end or cursor is invisible until a store lands on the block involved. The fault then shows as a wrong `init_o`, or as a hit or miss on a boundary block, in the same cycle as that store. A wrong age ranking is silent until the table is full and an allocation arrives. It then appears at the next store to the evicted or surviving regions, as a miss where a hit was due or as a wrong `hit_idx_o`. The bench therefore drives stores onto exact region edges, cursor positions and evicted regions, and compares every output on every cycle against a behavioural model.

// File: rtl/art_pkg.sv
`timescale 1ns/1ps
package art_pkg;
    localparam int ADDR_W   = 32;
    localparam int BLK_BITS = 6;
    // two spare bits: one for an exclusive bound at the top of memory, one for headroom
    localparam int BN_W     = ADDR_W - BLK_BITS + 2;

    typedef logic [BN_W-1:0] blk_t;

    typedef enum logic [1:0] {
        SWEEP_FWD     = 2'd0,
        SWEEP_BIDIR   = 2'd1,
        SWEEP_ILV     = 2'd2,
        SWEEP_FWD_ALT = 2'd3
    } sweep_e;

    typedef struct packed {
        logic vld;
        blk_t tag;   // first block at allocation time, used by free
        blk_t base;  // lowest block still tracked
        blk_t top;   // exclusive upper block
        blk_t cur;   // interleave cursor
    } entry_t;
endpackage

// File: rtl/art_lookup.sv
`timescale 1ns/1ps
module art_lookup
    import art_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int STRIDE_BLKS = 2,
    localparam int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  entry_t          tbl_i [DEPTH],
    input  blk_t            blk_i,
    input  logic [1:0]      mode_i,
    output logic            hit_o,
    output logic            init_o,
    output logic [IW-1:0]   idx_o,
    output entry_t          upd_o
);
    localparam blk_t STEP = blk_t'(STRIDE_BLKS);
    localparam blk_t ONE  = blk_t'(1);

    logic [DEPTH-1:0] in_rng;
    entry_t           sel;
    blk_t             last;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign in_rng[g] = tbl_i[g].vld && (blk_i >= tbl_i[g].base) && (blk_i < tbl_i[g].top);
    end

    // R3: lowest matching slot wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!hit_o && in_rng[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

    // truncation of the selected entry (R5, R6, R7, R8)
    always_comb begin
        sel    = tbl_i[idx_o];
        upd_o  = sel;
        init_o = 1'b0;
        last   = sel.top - ONE;
        case (sweep_e'(mode_i))
            SWEEP_BIDIR: begin
                if (blk_i == sel.base) begin
                    init_o     = hit_o;
                    upd_o.base = sel.base + ONE;
                end else if (blk_i == last) begin
                    init_o    = hit_o;
                    upd_o.top = last;
                end
                upd_o.cur = upd_o.base;
            end
            SWEEP_ILV: begin
                if (blk_i == sel.cur) begin
                    init_o = hit_o;
                    if (sel.cur + STEP < sel.top) begin
                        upd_o.cur = sel.cur + STEP;
                    end else begin
                        upd_o.base = sel.base + ONE;
                        upd_o.cur  = sel.base + ONE;
                        if (sel.base + ONE >= sel.tag + STEP) begin
                            upd_o.vld = 1'b0;
                        end
                    end
                end
            end
            default: begin
                if (blk_i == sel.base) begin
                    init_o     = hit_o;
                    upd_o.base = sel.base + ONE;
                end
                upd_o.cur = upd_o.base;
            end
        endcase
        if (upd_o.base >= upd_o.top) begin
            upd_o.vld = 1'b0;
        end
    end
endmodule

// File: rtl/art_repl.sv
`timescale 1ns/1ps
module art_repl #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld_i,
    input  logic [IW-1:0]    age_i  [DEPTH],
    output logic [IW-1:0]    rank_o [DEPTH],
    output logic [IW-1:0]    slot_o
);
    logic          has_free;
    logic [IW-1:0] free_slot;
    logic [IW-1:0] old_slot;

    // compacted age: number of surviving entries younger than this one
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rank_o[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (vld_i[j] && (age_i[j] < age_i[i])) begin
                    rank_o[i] = rank_o[i] + IW'(1);
                end
            end
        end
    end

    // R10: lowest empty slot, otherwise the oldest entry
    always_comb begin
        has_free  = 1'b0;
        free_slot = '0;
        old_slot  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                has_free  = 1'b1;
                free_slot = IW'(i);
            end
            if (rank_o[i] == IW'(DEPTH - 1)) begin
                old_slot = IW'(i);
            end
        end
        slot_o = has_free ? free_slot : old_slot;
    end
endmodule

// File: rtl/alloc_range_tracker.sv
`timescale 1ns/1ps
module alloc_range_tracker
    import art_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int STRIDE_BLKS = 2,
    localparam int IW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [1:0]          mode_i,
    input  logic                alloc_vld_i,
    input  logic [ADDR_W-1:0]   alloc_addr_i,
    input  logic [ADDR_W-1:0]   alloc_size_i,
    input  logic                free_vld_i,
    input  logic [ADDR_W-1:0]   free_addr_i,
    input  logic                st_vld_i,
    input  logic [ADDR_W-1:0]   st_addr_i,
    output logic                hit_o,
    output logic                init_o,
    output logic [IW-1:0]       hit_idx_o
);
    localparam int SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] ROUND = SUM_W'((1 << BLK_BITS) - 1);

    entry_t        tbl_q [DEPTH];
    entry_t        tbl_d [DEPTH];
    entry_t        mid   [DEPTH];
    logic [IW-1:0] age_q [DEPTH];
    logic [IW-1:0] age_d [DEPTH];
    logic [IW-1:0] rank  [DEPTH];

    logic [DEPTH-1:0] vld_mid;
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] live_vec;

    blk_t          st_blk;
    blk_t          free_blk;
    blk_t          new_base;
    blk_t          new_top;
    logic [SUM_W-1:0] end_sum;
    logic          ins;

    logic          lk_hit;
    logic          lk_init;
    logic [IW-1:0] lk_idx;
    entry_t        lk_upd;
    logic [IW-1:0] slot;

    assign st_blk   = blk_t'(st_addr_i >> BLK_BITS);
    assign free_blk = blk_t'(free_addr_i >> BLK_BITS);
    // R2: base aligned down, end rounded up to whole blocks
    assign new_base = blk_t'(alloc_addr_i >> BLK_BITS);
    assign end_sum  = {2'b00, alloc_addr_i} + {2'b00, alloc_size_i} + ROUND;
    assign new_top  = blk_t'(end_sum >> BLK_BITS);
    assign ins      = alloc_vld_i && (alloc_size_i != '0);

    art_lookup #(
        .DEPTH       (DEPTH),
        .STRIDE_BLKS (STRIDE_BLKS)
    ) u_lookup (
        .tbl_i  (tbl_q),
        .blk_i  (st_blk),
        .mode_i (mode_i),
        .hit_o  (lk_hit),
        .init_o (lk_init),
        .idx_o  (lk_idx),
        .upd_o  (lk_upd)
    );

    // R3: outputs only qualify with a store
    assign hit_o     = st_vld_i && lk_hit;
    assign init_o    = st_vld_i && lk_init;
    assign hit_idx_o = (st_vld_i && lk_hit) ? lk_idx : '0;

    // R11: truncation and free act before the insert
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mid[i] = tbl_q[i];
            if (st_vld_i && lk_init && (lk_idx == IW'(i))) begin
                mid[i] = lk_upd;
            end
            if (free_vld_i && mid[i].vld && (tbl_q[i].tag == free_blk)) begin
                mid[i].vld = 1'b0;  // R9
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign vld_mid[g]  = mid[g].vld;
        assign vld_vec[g]  = tbl_q[g].vld;
        assign live_vec[g] = tbl_q[g].base < tbl_q[g].top;
    end

    art_repl #(
        .DEPTH (DEPTH)
    ) u_repl (
        .vld_i  (vld_mid),
        .age_i  (age_q),
        .rank_o (rank),
        .slot_o (slot)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl_d[i] = mid[i];
            age_d[i] = mid[i].vld ? (rank[i] + IW'(ins)) : '0;
        end
        if (ins) begin
            tbl_d[slot] = '{vld: 1'b1, tag: new_base, base: new_base, top: new_top, cur: new_base};
            age_d[slot] = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= tbl_d[i];
                age_q[i] <= age_d[i];
            end
        end
    end
endmodule

// File: rtl/art_checker.sv
`timescale 1ns/1ps
module art_checker #(
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             st_vld_i,
    input logic             alloc_vld_i,
    input logic [31:0]      alloc_size_i,
    input logic             hit_o,
    input logic             init_o,
    input logic [IW-1:0]    hit_idx_o,
    input logic [DEPTH-1:0] vld_vec,
    input logic [DEPTH-1:0] live_vec
);
    a_r3_init_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_o |-> hit_o);

    a_r3_idx_zero_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (hit_idx_o == '0));

    a_r3_idx_names_live_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> vld_vec[hit_idx_o]);

    a_r3_no_hit_without_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_vld_i |-> !hit_o);

    a_r1_empty_table_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_vec == '0) |-> !hit_o);

    a_r8_live_entries_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_vec & ~live_vec) == '0);

    a_r2_alloc_leaves_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alloc_vld_i && (alloc_size_i != '0)) |=> (vld_vec != '0));
endmodule

bind alloc_range_tracker art_checker #(
    .DEPTH (DEPTH)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .st_vld_i     (st_vld_i),
    .alloc_vld_i  (alloc_vld_i),
    .alloc_size_i (alloc_size_i),
    .hit_o        (hit_o),
    .init_o       (init_o),
    .hit_idx_o    (hit_idx_o),
    .vld_vec      (vld_vec),
    .live_vec     (live_vec)
);

// File: tb/alloc_range_tracker_bench.sv
`timescale 1ns/1ps
module alloc_range_tracker_bench;
    localparam int DEPTH = 8;
    localparam int S     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        av = 1'b0, fv = 1'b0, sv = 1'b0;
    logic [31:0] aa = '0, as = '0, fa = '0, sa = '0;
    logic        hit_o, init_o;
    logic [2:0]  hit_idx_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    alloc_range_tracker #(.DEPTH(DEPTH), .STRIDE_BLKS(S)) u_alloc_range_tracker (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .alloc_vld_i(av), .alloc_addr_i(aa), .alloc_size_i(as),
        .free_vld_i(fv), .free_addr_i(fa),
        .st_vld_i(sv), .st_addr_i(sa),
        .hit_o(hit_o), .init_o(init_o), .hit_idx_o(hit_idx_o)
    );

    // behavioural model: per-slot ranges plus an insertion-order queue
    bit     m_vld  [DEPTH];
    longint m_tag  [DEPTH];
    longint m_base [DEPTH];
    longint m_top  [DEPTH];
    longint m_cur  [DEPTH];
    int     order  [$];

    function automatic void m_clear();
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        order.delete();
    endfunction

    function automatic void drop(int s);
        for (int k = 0; k < order.size(); k++) begin
            if (order[k] == s) begin
                order.delete(k);
                break;
            end
        end
    endfunction

    task automatic step(input string rq, input logic [1:0] md,
                        input logic a_v, input logic [31:0] a_a, input logic [31:0] a_s,
                        input logic f_v, input logic [31:0] f_a,
                        input logic s_v, input logic [31:0] s_a);
        bit e_hit, e_init, kill;
        int e_idx, fi;
        longint blk, nb, nt, nc;
        @(negedge clk);
        mode = md; av = a_v; aa = a_a; as = a_s; fv = f_v; fa = f_a; sv = s_v; sa = s_a;
        #1;
        e_hit = 0; e_init = 0; e_idx = 0; fi = -1; kill = 0;
        blk = longint'(s_a) >> 6;
        for (int i = 0; i < DEPTH; i++)
            if (fi < 0 && m_vld[i] && blk >= m_base[i] && blk < m_top[i]) fi = i;
        nb = 0; nt = 0; nc = 0;
        if (s_v && fi >= 0) begin
            e_hit = 1; e_idx = fi;
            nb = m_base[fi]; nt = m_top[fi]; nc = m_cur[fi];
            if (md == 2'd1) begin
                if (blk == m_base[fi]) begin e_init = 1; nb++; end
                else if (blk == m_top[fi] - 1) begin e_init = 1; nt--; end
                nc = nb;
            end else if (md == 2'd2) begin
                if (blk == m_cur[fi]) begin
                    e_init = 1;
                    if (m_cur[fi] + S < m_top[fi]) nc = m_cur[fi] + S;
                    else begin
                        nb = m_base[fi] + 1; nc = nb;
                        if (nb >= m_tag[fi] + S) kill = 1;
                    end
                end
            end else begin
                if (blk == m_base[fi]) begin e_init = 1; nb++; end
                nc = nb;
            end
            if (nb >= nt) kill = 1;
        end
        vectors++;
        if (hit_o !== e_hit || init_o !== e_init || hit_idx_o !== 3'(e_idx)) begin
            fails++;
            $display("FAIL %s: hit/init/idx = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     rq, hit_o, init_o, hit_idx_o, e_hit, e_init, e_idx);
        end
        // state update in the order the requirements give (R11)
        if (e_init) begin
            m_base[fi] = nb; m_top[fi] = nt; m_cur[fi] = nc;
            if (kill) begin m_vld[fi] = 0; drop(fi); end
        end
        if (f_v) begin
            for (int i = 0; i < DEPTH; i++)
                if (m_vld[i] && m_tag[i] == (longint'(f_a) >> 6)) begin
                    m_vld[i] = 0; drop(i);
                end
        end
        if (a_v && a_s != 0) begin
            int slot;
            slot = -1;
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
            if (slot < 0) slot = order.pop_front();
            m_vld[slot]  = 1;
            m_tag[slot]  = longint'(a_a) >> 6;
            m_base[slot] = m_tag[slot];
            m_top[slot]  = (longint'(a_a) + longint'(a_s) + 63) >> 6;
            m_cur[slot]  = m_base[slot];
            order.push_back(slot);
        end
    endtask

    task automatic st(input string rq, input logic [1:0] md, input logic [31:0] a);
        step(rq, md, 0, 0, 0, 0, 0, 1, a);
    endtask

    task automatic al(input string rq, input logic [31:0] a, input logic [31:0] s);
        step(rq, 2'd0, 1, a, s, 0, 0, 0, 0);
    endtask

    task automatic fr(input string rq, input logic [31:0] a);
        step(rq, 2'd0, 0, 0, 0, 1, a, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; av = 0; fv = 0; sv = 0;
        repeat (2) @(negedge clk);
        m_clear();
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        m_clear();
        do_reset();
        // R1: empty after reset
        st("R1", 2'd0, 32'h0000_1000);
        st("R1", 2'd0, 32'h0000_0000);
        // R4: alloc and store in the same cycle, store does not see it
        step("R4", 2'd0, 1, 32'h0000_1000, 32'h100, 0, 0, 1, 32'h0000_1000);
        // R2: span boundaries
        st("R2", 2'd0, 32'h0000_0FC0);
        st("R2", 2'd0, 32'h0000_1100);
        st("R2", 2'd0, 32'h0000_10FF);
        // R5: forward sweep
        st("R5", 2'd0, 32'h0000_1000);
        st("R5", 2'd0, 32'h0000_1040);
        st("R5", 2'd0, 32'h0000_1000);
        st("R5", 2'd0, 32'h0000_10C0);
        st("R5", 2'd3, 32'h0000_1080);
        // R8: fully consumed entry disappears
        st("R8", 2'd0, 32'h0000_10C0);
        st("R8", 2'd0, 32'h0000_10C0);
        // R2: unaligned allocation and zero size
        al("R2", 32'h0000_2010, 32'h40);
        st("R2", 2'd1, 32'h0000_2040);
        st("R2", 2'd1, 32'h0000_2080);
        al("R2", 32'h0000_3000, 32'h0);
        st("R2", 2'd0, 32'h0000_3000);
        // R6: bidirectional sweep
        al("R6", 32'h0000_4000, 32'h100);
        st("R6", 2'd1, 32'h0000_40C0);
        st("R6", 2'd1, 32'h0000_40C0);
        st("R6", 2'd1, 32'h0000_4000);
        st("R6", 2'd1, 32'h0000_4080);
        st("R6", 2'd1, 32'h0000_4040);
        st("R8", 2'd1, 32'h0000_4040);
        // R7: interleaved sweep, stride 2 over five blocks
        al("R7", 32'h0000_8000, 32'h140);
        st("R7", 2'd2, 32'h0000_8000);
        st("R7", 2'd2, 32'h0000_8040);
        st("R7", 2'd2, 32'h0000_8080);
        st("R7", 2'd2, 32'h0000_8100);
        st("R7", 2'd2, 32'h0000_8040);
        st("R7", 2'd2, 32'h0000_80C0);
        st("R8", 2'd2, 32'h0000_8080);
        // R7: cursor reset by a forward truncation
        al("R7", 32'h0080_0000, 32'h100);
        st("R7", 2'd2, 32'h0080_0000);
        st("R7", 2'd0, 32'h0080_0000);
        st("R7", 2'd2, 32'h0080_0040);
        // R9: free by original base
        do_reset();
        al("R9", 32'h0001_0000, 32'h80);
        al("R9", 32'h0002_0000, 32'h80);
        fr("R9", 32'h0003_0000);
        st("R9", 2'd0, 32'h0002_0040);
        fr("R9", 32'h0001_0000);
        st("R9", 2'd0, 32'h0001_0040);
        al("R9", 32'h0004_0000, 32'h100);
        st("R9", 2'd0, 32'h0004_0000);
        fr("R9", 32'h0004_0000);
        st("R9", 2'd0, 32'h0004_0040);
        // R10: FIFO replacement
        do_reset();
        for (int k = 0; k < DEPTH; k++) al("R10", 32'h0010_0000 * (k + 1), 32'h80);
        st("R10", 2'd0, 32'h0010_0040);
        st("R10", 2'd0, 32'h0080_0040);
        al("R10", 32'h0090_0000, 32'h80);
        st("R10", 2'd0, 32'h0010_0040);
        st("R10", 2'd0, 32'h0090_0040);
        fr("R10", 32'h0040_0000);
        al("R10", 32'h00A0_0000, 32'h80);
        al("R10", 32'h00B0_0000, 32'h80);
        st("R10", 2'd0, 32'h0020_0040);
        st("R10", 2'd0, 32'h00B0_0040);
        st("R10", 2'd0, 32'h00A0_0040);
        // R3: overlapping ranges, lowest index wins
        do_reset();
        al("R3", 32'h0060_0040, 32'h40);
        al("R3", 32'h0060_0000, 32'h100);
        st("R3", 2'd0, 32'h0060_0040);
        st("R3", 2'd0, 32'h0060_0040);
        step("R3", 2'd0, 0, 0, 0, 0, 0, 0, 32'h0060_0040);
        // R11: free and re-allocate the same base in one cycle
        step("R11", 2'd0, 1, 32'h0070_0000, 32'h80, 1, 32'h0060_0000, 0, 0);
        step("R11", 2'd0, 1, 32'h0070_0000, 32'h80, 1, 32'h0070_0000, 0, 0);
        st("R11", 2'd0, 32'h0070_0040);
        // random traffic against the model
        do_reset();
        for (int n = 0; n < 1500; n++) begin
            step("R2", 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0), 32'($urandom_range(0, 4095)), 32'($urandom_range(0, 400)),
                 ($urandom_range(0, 5) == 0), 32'($urandom_range(0, 63)) << 6,
                 ($urandom_range(0, 3) != 0), 32'($urandom_range(0, 4600)));
        end
        done = 1;
        finish_run();
    end
endmodule